// File: doc/BRIEF.md
# Packed Integer Dot-Product Lane Unit

This block is the integer dot-product datapath for one slice of a vector register. The vector is cut into 32-bit accumulator lanes. In byte mode, each lane multiplies four pairs of signed 8-bit elements. In halfword mode, each lane multiplies two pairs of signed 16-bit elements. The products are added together with the lane's incoming accumulator, and the 32-bit result replaces the accumulator. A per-lane predicate bit selects which lanes are updated. A lane with a clear predicate returns its incoming accumulator unchanged.

The unit is a fixed three-stage pipeline that can accept one operation on every cycle. The element-size select travels through the pipeline with its operands, so consecutive operations may use different modes. The vector width is a parameter with a default of 512 bits, which gives 16 lanes.

Top module: `idot_lanes`

## Requirements
- R1: With `in_half`=0, the value of lane j (bits 32j+31..32j) is acc + a0*b0 + a1*b1 + a2*b2 + a3*b3. Here element k is bits 8k+7..8k of that lane in `in_a` and `in_b`.
- R2: With `in_half`=1, the value of lane j is acc + a0*b0 + a1*b1. Here element k is bits 16k+15..16k of that lane.
- R3: Every element is a signed two's-complement value, and every product is signed.
- R4: The accumulation wraps modulo 2^32 and does not saturate.
- R5: A lane whose bit in `in_pred` is 0 outputs exactly its `in_acc` lane. Its operands have no effect.
- R6: `out_valid` equals `in_valid` delayed by 3 clock cycles, and an operation can be accepted on every cycle.
- R7: The mode is captured together with each operation's operands. Back-to-back operations with different modes each produce the result of their own mode.
- R8: While `rst_n` is low, `out_valid` and `out_acc` are 0.
- R9: `out_acc` changes only in a cycle in which `out_valid` is 1.
- R10: The number of lanes is VEC_W/32, and each lane's result depends only on that lane's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_half | input | 1 | 0: four byte pairs per lane; 1: two halfword pairs per lane |
| in_a | input | VEC_W | First source vector |
| in_b | input | VEC_W | Second source vector |
| in_acc | input | VEC_W | Accumulator vector |
| in_pred | input | VEC_W/32 | Per-lane update enable |
| out_valid | output | 1 | Result present on `out_acc` |
| out_acc | output | VEC_W | Updated accumulator vector |

## Verification
The hardest case to reach is one where several effects combine in the same cycle. A mode change on back-to-back operations must arrive while earlier operations of the other mode are still in flight. Wrap-around of the sum must also occur, and it only happens with extreme element values and an accumulator close to the 32-bit limit. Uniform random data almost never produces these cases. The stimulus therefore inserts directed operations with all elements at the most negative value, with mixed signs, and with a near-limit accumulator, and it issues them back to back in alternating modes. Random operations draw the valid bit, the mode and the predicate independently on every cycle, so partial predicates and idle gaps are interleaved with the directed cases.

// File: rtl/idot_lanes.sv
module idot_lanes #(
  parameter int VEC_W = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_half,
  input  logic [VEC_W-1:0]   in_a,
  input  logic [VEC_W-1:0]   in_b,
  input  logic [VEC_W-1:0]   in_acc,
  input  logic [VEC_W/32-1:0] in_pred,
  output logic               out_valid,
  output logic [VEC_W-1:0]   out_acc
);
  localparam int LANES = VEC_W / 32;
  localparam int BYTES = 4;
  localparam int HALVES = 2;

  logic               s1_valid, s1_half;
  logic [VEC_W-1:0]   s1_a, s1_b, s1_acc;
  logic [LANES-1:0]   s1_pred;

  logic               s2_valid;
  logic [VEC_W-1:0]   s2_acc;
  logic [LANES-1:0]   s2_pred;
  logic [31:0]        s2_prod [LANES][BYTES];
  logic [31:0]        prod_nxt [LANES][BYTES];

  logic [VEC_W-1:0]   lane_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_half  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_half  <= in_half;
    end
  end

  always_ff @(posedge clk) begin
    s1_a    <= in_a;
    s1_b    <= in_b;
    s1_acc  <= in_acc;
    s1_pred <= in_pred;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar k = 0; k < BYTES; k++) begin : g_elem
      logic signed [15:0] bp;
      assign bp = $signed(s1_a[l*32+k*8 +: 8]) * $signed(s1_b[l*32+k*8 +: 8]);
      if (k < HALVES) begin : g_hw
        logic signed [31:0] hp;
        assign hp = $signed(s1_a[l*32+k*16 +: 16]) * $signed(s1_b[l*32+k*16 +: 16]);
        assign prod_nxt[l][k] = s1_half ? hp : {{16{bp[15]}}, bp};
      end else begin : g_bo
        assign prod_nxt[l][k] = s1_half ? 32'd0 : {{16{bp[15]}}, bp};
      end
    end

    logic [31:0] sum;
    assign sum = s2_prod[l][0] + s2_prod[l][1] + s2_prod[l][2] + s2_prod[l][3]
               + s2_acc[l*32 +: 32];
    assign lane_res[l*32 +: 32] = s2_pred[l] ? sum : s2_acc[l*32 +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    s2_prod <= prod_nxt;
    s2_acc  <= s1_acc;
    s2_pred <= s1_pred;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) out_acc <= lane_res;
    end
  end
endmodule

module idot_lanes_chk #(
  parameter int VEC_W = 512
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [VEC_W-1:0]   in_acc,
  input logic [VEC_W/32-1:0] in_pred,
  input logic               out_valid,
  input logic [VEC_W-1:0]   out_acc
);
  localparam int LANES = VEC_W / 32;

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 3));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_acc == '0));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_acc));

  for (genvar l = 0; l < LANES; l++) begin : g_pc
    // R5
    masked_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(in_pred[l], 3)) |-> out_acc[l*32 +: 32] == $past(in_acc[l*32 +: 32], 3));
  end
endmodule

bind idot_lanes idot_lanes_chk #(.VEC_W(VEC_W)) u_idot_lanes_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
  .in_pred(in_pred), .out_valid(out_valid), .out_acc(out_acc));

// File: tb/test_idot_lanes.sv
module test_idot_lanes;
  localparam int W = 512;
  localparam int L = W / 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_half = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0, in_acc = '0;
  logic [L-1:0] in_pred = '0;
  logic out_valid;
  logic [W-1:0] out_acc;

  always #2 clk = ~clk;

  idot_lanes #(.VEC_W(W)) i_idot_lanes (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc), .in_pred(in_pred),
    .out_valid(out_valid), .out_acc(out_acc));

  int checks = 0, fails = 0, t = 0;
  bit done = 1'b0;
  logic [W-1:0] hist_e [4];
  logic         hist_v [4];
  string        hist_t [4];

  function automatic logic [31:0] lane_ref(logic h, logic [31:0] a, logic [31:0] b,
                                           logic [31:0] c, logic p);
    int s;
    s = int'(c);
    if (!p) return c;
    if (h) begin
      for (int k = 0; k < 2; k++)
        s += int'($signed(a[k*16 +: 16])) * int'($signed(b[k*16 +: 16]));
    end else begin
      for (int k = 0; k < 4; k++)
        s += int'($signed(a[k*8 +: 8])) * int'($signed(b[k*8 +: 8]));
    end
    return 32'(s);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic h, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [W-1:0] c,
                      input logic [L-1:0] p, input string tag);
    int s;
    logic [W-1:0] e;
    @(negedge clk);
    s = (t + 1) % 4;
    check(out_valid == hist_v[s], "R6 valid", W'(out_valid), W'(hist_v[s]));
    if (hist_v[s]) check(out_acc == hist_e[s], hist_t[s], out_acc, hist_e[s]);
    for (int l = 0; l < L; l++)
      e[l*32 +: 32] = lane_ref(h, a[l*32 +: 32], b[l*32 +: 32], c[l*32 +: 32], p[l]);
    in_valid = v; in_half = h; in_a = a; in_b = b; in_acc = c; in_pred = p;
    hist_v[t % 4] = v; hist_e[t % 4] = e; hist_t[t % 4] = tag;
    t++;
  endtask

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] r;
    for (int i = 0; i < W / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) begin hist_v[i] = 1'b0; hist_e[i] = '0; hist_t[i] = ""; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8: outputs cleared under reset
    check(out_valid == 1'b0 && out_acc == '0, "R8 reset", out_acc, '0);
    rst_n = 1'b1;

    // R3 R1: most negative bytes squared, all lanes
    step(1, 0, {W/8{8'h80}}, {W/8{8'h80}}, '0, '1, "R3 byte neg*neg");
    // R3 R2: mixed-sign halfword products, back to back with a mode change (R7)
    step(1, 1, {W/16{16'h8000}}, {W/16{16'h7FFF}}, {L{32'd5}}, '1, "R7 half mixed");
    step(1, 0, {W/8{8'h80}}, {W/8{8'h7F}}, {L{32'd100}}, '1, "R7 byte mixed");
    // R4: halfword products reach 2^31 and wrap
    step(1, 1, {W/16{16'h8000}}, {W/16{16'h8000}}, {L{32'h7FFF_FFFF}}, '1, "R4 half wrap");
    step(1, 0, {W/8{8'h7F}}, {W/8{8'h7F}}, {L{32'h7FFF_FFFF}}, '1, "R4 byte wrap");
    // R5: alternate lanes masked, operands nonzero
    step(1, 0, {W/8{8'h11}}, {W/8{8'h22}}, {L{32'hCAFE_0001}}, {L/2{2'b01}}, "R5 mask");
    step(1, 1, {W/16{16'h1234}}, {W/16{16'hFEDC}}, {L{32'h0BAD_F00D}}, '0, "R5 all off");
    // R10: only one lane carries data
    step(1, 0, {{W-32{1'b0}}, 32'h7F80_01FF}, {{W-32{1'b0}}, 32'h807F_FF01}, '0, '1, "R10 one lane");
    step(0, 0, '1, '1, '1, '1, "R9 idle");
    step(0, 1, '0, '0, '0, '0, "R9 idle");

    for (int n = 0; n < 3000; n++)
      step(($urandom % 4) != 0, $urandom % 2, rnd_vec(), rnd_vec(), rnd_vec(),
           L'($urandom), "R1/R2 random");
    for (int n = 0; n < 400; n++)
      step(1, n[0], rnd_vec(), rnd_vec(), rnd_vec(), '1, "R6 R7 burst");
    repeat (4) step(0, 0, '0, '0, '0, '0, "R9 flush");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule